// File: doc/BRIEF.md
# Five-State Snooping Invalidate Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped tag array that belongs to one write-back cache on a shared bus. It accepts processor reads and writes over a valid/ready handshake, decides whether each access can finish locally, and otherwise drives one bus transaction at a time: line read, read-for-ownership, invalidate or writeback. At the same time it watches every transaction that other caches put on the bus. It answers in the same cycle with a shared flag, and with a supply flag when it holds the only up-to-date copy.

Lines are Invalid, Shared, Exclusive, Owned or Modified. The Owned state lets a dirty line be read by other caches without first being written back to memory. This cache stays responsible for supplying that line and for writing it back when it is evicted.

Back-pressure rules. A processor request moves when `cpu_req_valid` and `cpu_req_ready` are both high at a clock edge. Ready is low while a bus transaction is outstanding and in any cycle in which a snoop is presented. `cpu_done` pulses once per accepted request, when the access has completed. A bus request holds `bus_req_valid` high until a cycle in which `bus_grant` is high; the transaction completes at that edge. The environment never raises `bus_grant` and `snoop_valid` in the same cycle.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `bus_req_valid` and `cpu_done` are low.
- R2: A read miss issues a line read (command code 1). The line becomes Exclusive if `bus_shared_in` is low in the grant cycle, and Shared if it is high. A read hit in any valid state finishes with no bus transaction.
- R3: A write hit on an Exclusive or Modified line finishes with no bus transaction, and the line becomes Modified. On every bus-free hit, `cpu_done` is high in the cycle after acceptance.
- R4: A write hit on a Shared or Owned line issues an invalidate (code 3), and a write miss issues a read-for-ownership (code 2). Either way the line becomes Modified at the grant.
- R5: A miss whose victim line is Modified or Owned first issues a writeback (code 4) carrying the victim's line address, and then issues the fill. A miss whose victim is clean goes straight to the fill.
- R6: For a snooped read, read-for-ownership or invalidate (codes 1, 2, 3), `snoop_shared` is high in the same cycle if the line is held in any valid state. `snoop_supply` is high in that cycle if the line is Modified or Owned. Snooped writebacks (code 4) draw no response and change no state.
- R7: A snooped read hit changes Exclusive to Shared and Modified to Owned, and leaves Shared and Owned unchanged.
- R8: A snooped read-for-ownership or invalidate hit makes the line Invalid.
- R9: Only one bus transaction is outstanding. `cpu_req_ready` is low while it is pending and whenever `snoop_valid` is high. `bus_req_cmd` and `bus_req_addr` hold steady until the grant, except as R10 and R11 allow. `cpu_done` is high in the cycle after the grant of the final transaction.
- R10: If a pending invalidate's line is invalidated by a snoop before the grant, the request turns into a read-for-ownership of the same line.
- R11: If a pending writeback's victim is taken by a snooped read-for-ownership or invalidate before the grant, the writeback is dropped and the fill request follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address; low IDX_W bits index the array |
| cpu_done | output | 1 | One-cycle pulse when an accepted access completes |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 3 | 1 read, 2 read-for-ownership, 3 invalidate, 4 writeback |
| bus_req_addr | output | ADDR_W | Line address of the requested transaction |
| bus_grant | input | 1 | Requested transaction completes at this edge |
| bus_shared_in | input | 1 | Another cache holds the line being read (sampled at grant) |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 3 | Snooped command, same codes as bus_req_cmd |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_shared | output | 1 | This cache holds the snooped line |
| snoop_supply | output | 1 | This cache will supply the snooped line's data |

## Verification
Snoop responses are combinational, so the bench presents a snoop after a falling edge and samples `snoop_shared` and `snoop_supply` in that same low phase. The state change shows up only in the next snoop or request. A bus-free hit raises `cpu_done` one edge after acceptance. A bus request is visible one edge after acceptance, the fill request one edge after a writeback grant, and `cpu_done` one edge after the final grant. The bench steps through exactly these edges and samples each output at the falling edge in between. The bench checks the R10 and R11 rewrites at the falling edge after the snoop that causes them.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_O = 3'd3,
    LS_M = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_INV  = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_WB   = 2'd1,
    F_XFER = 2'd2
  } req_fsm_e;

  function automatic logic st_dirty(line_st_e s);
    return (s == LS_M) || (s == LS_O);
  endfunction

endpackage

// File: rtl/snc_line_table.sv
module snc_line_table
  import snc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_e         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_e         b_st,
  input  logic             a_we,
  input  logic [TAG_W-1:0] a_wtag,
  input  line_st_e         a_wst,
  input  logic             b_we,
  input  line_st_e         b_wst
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  line_st_e         st_mem  [LINES];

  // port A (request sequencer) wins over port B (snoop) on the same line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_mem[i] <= '0;
        st_mem[i]  <= LS_I;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (a_we && a_idx == IDX_W'(i)) begin
          tag_mem[i] <= a_wtag;
          st_mem[i]  <= a_wst;
        end else if (b_we && b_idx == IDX_W'(i)) begin
          st_mem[i]  <= b_wst;
        end
      end
    end
  end

  assign a_tag = tag_mem[a_idx];
  assign a_st  = st_mem[a_idx];
  assign b_tag = tag_mem[b_idx];
  assign b_st  = st_mem[b_idx];

endmodule

// File: rtl/snc_snoop_unit.sv
module snc_snoop_unit
  import snc_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             snoop_valid,
  input  logic [2:0]       snoop_cmd,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  output logic             resp_shared,
  output logic             resp_supply,
  output logic             upd_en,
  output line_st_e         upd_st,
  output logic             kill
);
  logic present;
  logic is_rd;
  logic is_own;

  assign present = snoop_valid && (line_st != LS_I) && (line_tag == snoop_tag);
  assign is_rd   = (snoop_cmd == BC_RD);
  assign is_own  = (snoop_cmd == BC_RDX) || (snoop_cmd == BC_INV);

  always_comb begin
    resp_shared = 1'b0;
    resp_supply = 1'b0;
    upd_en      = 1'b0;
    upd_st      = line_st;
    kill        = 1'b0;
    if (present && (is_rd || is_own)) begin
      resp_shared = 1'b1;
      resp_supply = st_dirty(line_st);
      if (is_own) begin
        upd_en = 1'b1;
        upd_st = LS_I;
        kill   = 1'b1;
      end else begin
        unique case (line_st)
          LS_E:    begin upd_en = 1'b1; upd_st = LS_S; end
          LS_M:    begin upd_en = 1'b1; upd_st = LS_O; end
          default: begin upd_en = 1'b0; upd_st = line_st; end
        endcase
      end
    end
  end

endmodule

// File: rtl/snc_req_fsm.sv
module snc_req_fsm
  import snc_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 12,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              cpu_done,
  input  logic              snoop_valid,
  input  logic [IDX_W-1:0]  snoop_idx,
  input  logic              snoop_kill,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  output logic              bus_req_valid,
  output logic [2:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [IDX_W-1:0]  look_idx,
  input  logic [TAG_W-1:0]  look_tag,
  input  line_st_e          look_st,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output line_st_e          wr_st
);
  req_fsm_e         fsm_q;
  bus_cmd_e         cmd_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] vtag_q;
  logic             done_q;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             accept;
  logic             hit;
  logic             own_kill;

  assign req_idx  = cpu_req_addr[IDX_W-1:0];
  assign req_tag  = cpu_req_addr[ADDR_W-1:IDX_W];
  assign look_idx = (fsm_q == F_IDLE) ? req_idx : idx_q;
  assign hit      = (look_st != LS_I) && (look_tag == req_tag);
  assign own_kill = snoop_kill && (snoop_idx == idx_q);

  assign cpu_req_ready = (fsm_q == F_IDLE) && !snoop_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign cpu_done      = done_q;
  assign bus_req_valid = (fsm_q != F_IDLE);
  assign bus_req_cmd   = (fsm_q == F_WB) ? BC_WB : cmd_q;
  assign bus_req_addr  = (fsm_q == F_WB) ? {vtag_q, idx_q} : {tag_q, idx_q};

  // table write requests from the sequencer
  always_comb begin
    wr_en  = 1'b0;
    wr_tag = tag_q;
    wr_st  = LS_I;
    unique case (fsm_q)
      F_IDLE: begin
        if (accept && hit && cpu_req_write &&
            (look_st == LS_E || look_st == LS_M)) begin
          wr_en  = 1'b1;
          wr_tag = req_tag;
          wr_st  = LS_M;
        end
      end
      F_WB: begin
        if (bus_grant) begin
          wr_en  = 1'b1;
          wr_tag = vtag_q;
          wr_st  = LS_I;
        end
      end
      F_XFER: begin
        if (bus_grant) begin
          wr_en  = 1'b1;
          wr_tag = tag_q;
          if (cmd_q == BC_RD) wr_st = bus_shared_in ? LS_S : LS_E;
          else                wr_st = LS_M;
        end
      end
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      cmd_q  <= BC_NONE;
      idx_q  <= '0;
      tag_q  <= '0;
      vtag_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (fsm_q)
        F_IDLE: begin
          if (accept) begin
            idx_q  <= req_idx;
            tag_q  <= req_tag;
            vtag_q <= look_tag;
            if (hit) begin
              if (cpu_req_write && (look_st == LS_S || look_st == LS_O)) begin
                cmd_q <= BC_INV;
                fsm_q <= F_XFER;
              end else begin
                done_q <= 1'b1;
              end
            end else begin
              cmd_q <= cpu_req_write ? BC_RDX : BC_RD;
              fsm_q <= st_dirty(look_st) ? F_WB : F_XFER;
            end
          end
        end
        F_WB: begin
          if (own_kill || bus_grant) fsm_q <= F_XFER;
        end
        F_XFER: begin
          if (bus_grant) begin
            done_q <= 1'b1;
            fsm_q  <= F_IDLE;
            cmd_q  <= BC_NONE;
          end else if (own_kill && cmd_q == BC_INV) begin
            cmd_q <= BC_RDX;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_done,
  output logic              bus_req_valid,
  output logic [2:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [2:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared,
  output logic              snoop_supply
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] look_idx;
  logic [TAG_W-1:0] look_tag;
  line_st_e         look_st;
  logic [IDX_W-1:0] snp_idx;
  logic [TAG_W-1:0] snp_tag;
  logic [TAG_W-1:0] snp_line_tag;
  line_st_e         snp_line_st;
  logic             a_we;
  logic [TAG_W-1:0] a_wtag;
  line_st_e         a_wst;
  logic             b_we;
  line_st_e         b_wst;
  logic             snp_kill;

  assign snp_idx = snoop_addr[IDX_W-1:0];
  assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

  snc_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (look_idx),
    .a_tag  (look_tag),
    .a_st   (look_st),
    .b_idx  (snp_idx),
    .b_tag  (snp_line_tag),
    .b_st   (snp_line_st),
    .a_we   (a_we),
    .a_wtag (a_wtag),
    .a_wst  (a_wst),
    .b_we   (b_we),
    .b_wst  (b_wst)
  );

  snc_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snoop_valid (snoop_valid),
    .snoop_cmd   (snoop_cmd),
    .snoop_tag   (snp_tag),
    .line_tag    (snp_line_tag),
    .line_st     (snp_line_st),
    .resp_shared (snoop_shared),
    .resp_supply (snoop_supply),
    .upd_en      (b_we),
    .upd_st      (b_wst),
    .kill        (snp_kill)
  );

  snc_req_fsm #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_ready (cpu_req_ready),
    .cpu_done      (cpu_done),
    .snoop_valid   (snoop_valid),
    .snoop_idx     (snp_idx),
    .snoop_kill    (snp_kill),
    .bus_grant     (bus_grant),
    .bus_shared_in (bus_shared_in),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (bus_req_cmd),
    .bus_req_addr  (bus_req_addr),
    .look_idx      (look_idx),
    .look_tag      (look_tag),
    .look_st       (look_st),
    .wr_en         (a_we),
    .wr_tag        (a_wtag),
    .wr_st         (a_wst)
  );

endmodule

// File: rtl/snc_ctrl_checker.sv
module snc_ctrl_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_done,
  input logic              bus_req_valid,
  input logic [2:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_grant,
  input logic              snoop_valid,
  input logic [2:0]        snoop_cmd,
  input logic              snoop_shared,
  input logic              snoop_supply
);
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready);

  a_r9_snoop_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> !cpu_req_ready);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_grant) |=> bus_req_valid);

  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_grant && !snoop_valid) |=>
      ($stable(bus_req_cmd) && $stable(bus_req_addr)));

  a_r9_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_grant && bus_req_cmd != 3'd4) |=> cpu_done);

  a_r9_grant_snoop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_grant && snoop_valid));

  a_r6_supply_shared: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_supply |-> snoop_shared);

  a_r6_wb_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_cmd == 3'd4) |-> (!snoop_shared && !snoop_supply));

  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_valid |-> (!snoop_shared && !snoop_supply));

endmodule

bind snoop_coherence_ctrl snc_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_ready (cpu_req_ready),
  .cpu_done      (cpu_done),
  .bus_req_valid (bus_req_valid),
  .bus_req_cmd   (bus_req_cmd),
  .bus_req_addr  (bus_req_addr),
  .bus_grant     (bus_grant),
  .snoop_valid   (snoop_valid),
  .snoop_cmd     (snoop_cmd),
  .snoop_shared  (snoop_shared),
  .snoop_supply  (snoop_supply)
);

// File: tb/snoop_coherence_ctrl_test.sv
module snoop_coherence_ctrl_test;
  localparam int AW = 12;
  localparam logic [2:0] C_NONE = 3'd0, C_RD = 3'd1, C_RDX = 3'd2, C_INV = 3'd3, C_WB = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic cpu_req_ready, cpu_done;
  logic bus_req_valid;
  logic [2:0] bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic bus_grant = 1'b0, bus_shared_in = 1'b0;
  logic snoop_valid = 1'b0;
  logic [2:0] snoop_cmd = '0;
  logic [AW-1:0] snoop_addr = '0;
  logic snoop_shared, snoop_supply;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  snoop_coherence_ctrl #(.ADDR_W(AW), .IDX_W(3)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr), .cpu_done(cpu_done),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_shared(snoop_shared), .snoop_supply(snoop_supply)
  );

  // kind: 0 cpu read, 1 cpu write, 2 snoop
  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  scmd;
    logic [11:0] addr;
    logic [11:0] vaddr;
    logic        shin;
    logic [2:0]  e1;
    logic [2:0]  e2;
    logic        esh;
    logic        esup;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 12'h010, 12'h000, 1'b0, 3'd1, 3'd0, 1'b0, 1'b0, 4'd2},  // R2 miss -> E
    '{2'd1, 3'd0, 12'h010, 12'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd3},  // R3 silent E->M
    '{2'd2, 3'd1, 12'h010, 12'h000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 4'd7},  // R7 M->O, supply
    '{2'd2, 3'd1, 12'h010, 12'h000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 4'd7},  // R7 O stays O
    '{2'd1, 3'd0, 12'h010, 12'h000, 1'b0, 3'd3, 3'd0, 1'b0, 1'b0, 4'd4},  // R4 O write -> INV
    '{2'd2, 3'd2, 12'h010, 12'h000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 4'd8},  // R8 RDX on M
    '{2'd2, 3'd1, 12'h010, 12'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd8},  // R8 now Invalid
    '{2'd0, 3'd0, 12'h021, 12'h000, 1'b1, 3'd1, 3'd0, 1'b0, 1'b0, 4'd2},  // R2 miss -> S
    '{2'd2, 3'd1, 12'h021, 12'h000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 4'd6},  // R6 S no supply
    '{2'd0, 3'd0, 12'h021, 12'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd2},  // R2 read hit
    '{2'd1, 3'd0, 12'h021, 12'h000, 1'b0, 3'd3, 3'd0, 1'b0, 1'b0, 4'd4},  // R4 S write -> INV
    '{2'd0, 3'd0, 12'h029, 12'h021, 1'b0, 3'd4, 3'd1, 1'b0, 1'b0, 4'd5},  // R5 M victim WB
    '{2'd2, 3'd1, 12'h021, 12'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd5},  // R5 victim gone
    '{2'd1, 3'd0, 12'h029, 12'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd3},  // R3 E->M
    '{2'd1, 3'd0, 12'h032, 12'h000, 1'b0, 3'd2, 3'd0, 1'b0, 1'b0, 4'd4},  // R4 write miss RDX
    '{2'd2, 3'd4, 12'h032, 12'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 WB snoop ignored
    '{2'd2, 3'd1, 12'h032, 12'h000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 4'd6},  // R6 still M -> O
    '{2'd0, 3'd0, 12'h03A, 12'h032, 1'b1, 3'd4, 3'd1, 1'b0, 1'b0, 4'd5},  // R5 O victim WB
    '{2'd2, 3'd3, 12'h03A, 12'h000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 4'd8},  // R8 INV on S
    '{2'd0, 3'd0, 12'h03A, 12'h000, 1'b0, 3'd1, 3'd0, 1'b0, 1'b0, 4'd2},  // R2 refetch -> E
    '{2'd2, 3'd1, 12'h03A, 12'h000, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 4'd7},  // R7 E->S
    '{2'd1, 3'd0, 12'h03A, 12'h000, 1'b0, 3'd3, 3'd0, 1'b0, 1'b0, 4'd4},  // R4 S write INV
    '{2'd0, 3'd0, 12'h042, 12'h03A, 1'b0, 3'd4, 3'd1, 1'b0, 1'b0, 4'd5},  // R5 M victim WB
    '{2'd0, 3'd0, 12'h04A, 12'h000, 1'b0, 3'd1, 3'd0, 1'b0, 1'b0, 4'd5},  // R5 clean victim
    '{2'd2, 3'd1, 12'h042, 12'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd5}   // R5 dropped line
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cpu_issue(input logic wr, input logic [AW-1:0] a);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    @(posedge clk);
    #1 cpu_req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic grant(input logic sh);
    bus_grant = 1'b1;
    bus_shared_in = sh;
    @(posedge clk);
    #1 bus_grant = 1'b0;
    bus_shared_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic snoop(input logic [2:0] c, input logic [AW-1:0] a,
                       input logic esh, input logic esup, input string rq);
    @(negedge clk);
    snoop_valid = 1'b1;
    snoop_cmd = c;
    snoop_addr = a;
    #1;
    check(snoop_shared == esh, rq, "snoop_shared", snoop_shared, esh);
    check(snoop_supply == esup, rq, "snoop_supply", snoop_supply, esup);
    check(cpu_req_ready == 1'b0, "R9", "ready during snoop", cpu_req_ready, 0);
    @(posedge clk);
    #1 snoop_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R1", "ready", cpu_req_ready, 1);
    check(bus_req_valid == 1'b0, "R1", "bus_req_valid", bus_req_valid, 0);
    check(cpu_done == 1'b0, "R1", "cpu_done", cpu_done, 0);
    snoop(C_RD, 12'h010, 1'b0, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v  = VECS[i];
      rq = $sformatf("R%0d", v.rq);
      if (v.kind == 2'd2) begin
        snoop(v.scmd, v.addr, v.esh, v.esup, rq);
      end else begin
        cpu_issue(v.kind[0], v.addr);
        if (v.e1 == C_NONE) begin
          check(cpu_done == 1'b1, rq, "hit done", cpu_done, 1);
          check(bus_req_valid == 1'b0, rq, "hit bus idle", bus_req_valid, 0);
        end else begin
          check(bus_req_valid == 1'b1, rq, "bus_req_valid", bus_req_valid, 1);
          check(cpu_req_ready == 1'b0, "R9", "ready while pending", cpu_req_ready, 0);
          check(bus_req_cmd == v.e1, rq, "cmd1", bus_req_cmd, v.e1);
          check(bus_req_addr == ((v.e1 == C_WB) ? v.vaddr : v.addr), rq, "addr1",
                bus_req_addr, (v.e1 == C_WB) ? v.vaddr : v.addr);
          if (v.e1 == C_WB) begin
            grant(1'b0);
            check(cpu_done == 1'b0, rq, "no done after WB", cpu_done, 0);
            check(bus_req_cmd == v.e2, rq, "cmd2", bus_req_cmd, v.e2);
            check(bus_req_addr == v.addr, rq, "addr2", bus_req_addr, v.addr);
          end
          grant(v.shin);
          check(cpu_done == 1'b1, "R9", "done after grant", cpu_done, 1);
          check(bus_req_valid == 1'b0, "R9", "bus idle after", bus_req_valid, 0);
        end
      end
    end

    // R9 snoop alone drops ready while idle
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = C_WB; snoop_addr = 12'h000;
    #1 check(cpu_req_ready == 1'b0, "R9", "idle ready with snoop", cpu_req_ready, 0);
    @(posedge clk); #1 snoop_valid = 1'b0;
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R9", "idle ready restored", cpu_req_ready, 1);

    // R10 pending invalidate turned into read-for-ownership
    cpu_issue(1'b0, 12'h05B);
    grant(1'b1);                                   // line now Shared
    cpu_issue(1'b1, 12'h05B);
    check(bus_req_cmd == C_INV, "R10", "cmd before snoop", bus_req_cmd, C_INV);
    snoop_valid = 1'b1; snoop_cmd = C_INV; snoop_addr = 12'h05B;
    #1 check(snoop_shared == 1'b1, "R10", "snoop hit", snoop_shared, 1);
    @(posedge clk); #1 snoop_valid = 1'b0;
    @(negedge clk);
    check(bus_req_cmd == C_RDX, "R10", "cmd after snoop", bus_req_cmd, C_RDX);
    check(bus_req_addr == 12'h05B, "R10", "addr after snoop", bus_req_addr, 12'h05B);
    grant(1'b0);
    check(cpu_done == 1'b1, "R10", "done", cpu_done, 1);
    snoop(C_RD, 12'h05B, 1'b1, 1'b1, "R10");

    // R11 pending writeback dropped when victim is taken
    cpu_issue(1'b1, 12'h064);
    grant(1'b0);                                   // line Modified
    cpu_issue(1'b0, 12'h06C);
    check(bus_req_cmd == C_WB, "R11", "wb cmd", bus_req_cmd, C_WB);
    check(bus_req_addr == 12'h064, "R11", "wb addr", bus_req_addr, 12'h064);
    snoop_valid = 1'b1; snoop_cmd = C_RDX; snoop_addr = 12'h064;
    #1 check(snoop_supply == 1'b1, "R11", "victim supplied", snoop_supply, 1);
    @(posedge clk); #1 snoop_valid = 1'b0;
    @(negedge clk);
    check(bus_req_cmd == C_RD, "R11", "fill cmd", bus_req_cmd, C_RD);
    check(bus_req_addr == 12'h06C, "R11", "fill addr", bus_req_addr, 12'h06C);
    grant(1'b0);
    check(cpu_done == 1'b1, "R11", "done", cpu_done, 1);
    snoop(C_RD, 12'h064, 1'b0, 1'b0, "R11");
    snoop(C_RD, 12'h06C, 1'b1, 1'b0, "R11");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule